// File: doc/BRIEF.md
# Time-over-threshold hit recorder

This block is the digital back end of one detector channel. On every clock it samples the channel's discriminator bit. When the bit goes high it starts a hit. It takes the coarse time from a free-running 5-bit time base at the first high sample. It then counts how many consecutive samples stay high. When the bit drops, the count is compressed into a 4-bit logarithmic code, paired with the timestamp, and written into a four-entry first-in first-out hit store.

The readout side sees the oldest stored hit at the head outputs. It frees that entry with a one-cycle release strobe. Capture and release are independent, so a hit can be stored on the same edge that another is released. When all four entries are taken, a finishing hit is discarded and a sticky overflow flag is raised. Entries that are already stored are never overwritten.

Top module: `tot_hit_recorder`

## Requirements
- R1: After synchronous reset, `head_valid_o`, `full_o` and `overflow_o` are all 0.
- R2: A hit's timestamp is the value of `tbase_i` on the first clock edge at which `disc_i` is sampled high after being low. Later time base values during the hit have no effect. The 5-bit value wraps from 31 to 0 with no carry.
- R3: The linear length N of a hit is the number of consecutive edges at which `disc_i` is sampled high. The record is written on the first edge at which `disc_i` is sampled low again, and it is visible right after that edge.
- R4: The stored code is 1 for N = 1. For N >= 2 it is 2p + h, where p is the bit position of the most significant set bit of N and h is the bit just below it. Codes above 15 saturate to 15, so every N >= 192 gives 15. Code 0 is never stored.
- R5: Hits leave in arrival order. `head_*` shows the oldest stored hit while `head_valid_o` is 1. `full_o` is 1 exactly when 4 hits are stored.
- R6: A hit that completes while 4 hits are stored is dropped. `overflow_o` is then set and stays 1 until reset, and the stored hits and their order are unchanged.
- R7: `release_i` sampled high on an edge frees the head entry on that edge. A hit that completes on that same edge still sees the store as full and is dropped. A hit that completes on the next edge is stored.
- R8: `release_i` with an empty store does nothing, and the next hit becomes the head normally.
- R9: With the store neither empty nor full, a hit that completes on the same edge as a release is stored while the head is freed, so the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| disc_i | input | 1 | Discriminator output |
| tbase_i | input | 5 | Free-running coarse time base |
| release_i | input | 1 | Frees the head entry |
| head_valid_o | output | 1 | Store holds at least one hit |
| head_stamp_o | output | 5 | Timestamp of the oldest hit |
| head_code_o | output | 4 | Length code of the oldest hit |
| full_o | output | 1 | Four hits stored |
| overflow_o | output | 1 | Sticky: a hit was dropped |

## Verification
The assertions assume that `disc_i`, `tbase_i` and `release_i` are settled well before each rising edge. The checks on timestamp capture assume the time base holds a defined value whenever the discriminator rises. The bench changes all inputs only on falling clock edges and always drives the time base. It sweeps every length from 1 to 200, plus one pulse longer than the counter range, and moves the time base through the wrap point. It then lines up hit completion with release on the same edge, both with the store full and with it partly filled.

// File: rtl/tot_hit_pkg.sv
package tot_hit_pkg;
    localparam int TS_W     = 5;
    localparam int CODE_W   = 4;
    localparam int SAT_W    = 8;
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int DEF_DEPTH = 4;

    typedef struct packed {
        logic [TS_W-1:0]   stamp;
        logic [CODE_W-1:0] code;
    } hit_rec_t;

    // Logarithmic compression of a saturating linear tick count
    function automatic logic [CODE_W-1:0] tot_code(input logic [SAT_W-1:0] n);
        int p;
        int c;
        p = -1;
        for (int i = 0; i < SAT_W; i++)
            if (n[i]) p = i;
        if (p < 0)
            c = 0;
        else if (p == 0)
            c = 1;
        else begin
            c = 2 * p + (n[p-1] ? 1 : 0);
            if (c > CODE_MAX) c = CODE_MAX;
        end
        return c[CODE_W-1:0];
    endfunction
endpackage

// File: rtl/tot_pulse_meter.sv
module tot_pulse_meter
    import tot_hit_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            disc_i,
    input  logic [TS_W-1:0] tbase_i,
    output logic            done_o,
    output hit_rec_t        rec_o
);
    logic             disc_q;
    logic [SAT_W-1:0] ticks;
    logic [TS_W-1:0]  stamp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            disc_q  <= 1'b0;
            ticks   <= '0;
            stamp_q <= '0;
        end else begin
            disc_q <= disc_i;
            if (disc_i && !disc_q) begin
                ticks   <= SAT_W'(1);
                stamp_q <= tbase_i;
            end else if (disc_i && ticks != '1) begin
                ticks <= ticks + SAT_W'(1);
            end
        end
    end

    assign done_o      = disc_q && !disc_i;
    assign rec_o.stamp = stamp_q;
    assign rec_o.code  = tot_code(ticks);

    // R2: timestamp comes from the first high sample
    assert_stamp_latch_R2: assert property (@(posedge clk) disable iff (rst)
        (disc_i && !disc_q) |=> (stamp_q == $past(tbase_i)));
    // R2: timestamp held for the rest of the pulse
    assert_stamp_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (disc_i && disc_q) |=> $stable(stamp_q));
    // R4: no completed hit carries the reserved code
    assert_code_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (rec_o.code != '0));
    // R3: length grows without wrapping while high
    assert_ticks_monotone_R3: assert property (@(posedge clk) disable iff (rst)
        (disc_i && disc_q) |=> (ticks >= $past(ticks)));
endmodule

// File: rtl/hit_slot_store.sv
module hit_slot_store
    import tot_hit_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push_i,
    input  hit_rec_t rec_i,
    input  logic     pop_i,
    output logic     valid_o,
    output hit_rec_t head_o,
    output logic     full_o,
    output logic     ovf_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    hit_rec_t        slots [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   occ;
    logic            push_ok, pop_ok;

    assign push_ok = push_i && (occ != FULL_CNT);
    assign pop_ok  = pop_i && (occ != '0);

    always_ff @(posedge clk) begin
        if (push_ok) slots[wr_ptr] <= rec_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
            ovf_o  <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PW'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PW'(1);
            if (push_ok && !pop_ok)      occ <= occ + CW'(1);
            else if (pop_ok && !push_ok) occ <= occ - CW'(1);
            if (push_i && !push_ok) ovf_o <= 1'b1;
        end
    end

    assign valid_o = (occ != '0);
    assign full_o  = (occ == FULL_CNT);
    assign head_o  = slots[rd_ptr];

    // R5: occupancy never exceeds the store size
    assert_occ_bound_R5: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_CNT);
    // R6: a hit arriving when full raises the overflow flag
    assert_drop_sets_ovf_R6: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o) |=> ovf_o);
    // R6: overflow is sticky
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);
    // R6: stored hits untouched by a dropped one
    assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o && !pop_i) |=> (full_o && $stable(head_o)));
    // R8: release on an empty store has no effect
    assert_empty_release_R8: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !valid_o && !push_i) |=> !valid_o);
    // R9: simultaneous store and release keeps occupancy
    assert_concurrent_R9: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && valid_o && !full_o) |=> $stable(occ));
endmodule

// File: rtl/tot_hit_recorder.sv
module tot_hit_recorder
    import tot_hit_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disc_i,
    input  logic [TS_W-1:0]   tbase_i,
    input  logic              release_i,
    output logic              head_valid_o,
    output logic [TS_W-1:0]   head_stamp_o,
    output logic [CODE_W-1:0] head_code_o,
    output logic              full_o,
    output logic              overflow_o
);
    logic     done;
    hit_rec_t rec;
    hit_rec_t head;

    tot_pulse_meter u_meter (
        .clk     (clk),
        .rst     (rst),
        .disc_i  (disc_i),
        .tbase_i (tbase_i),
        .done_o  (done),
        .rec_o   (rec)
    );

    hit_slot_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .push_i  (done),
        .rec_i   (rec),
        .pop_i   (release_i),
        .valid_o (head_valid_o),
        .head_o  (head),
        .full_o  (full_o),
        .ovf_o   (overflow_o)
    );

    assign head_stamp_o = head.stamp;
    assign head_code_o  = head.code;

    // R1: flags clear on the cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!head_valid_o && !full_o && !overflow_o));
endmodule

// File: tb/test_tot_hit_recorder.sv
module test_tot_hit_recorder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       disc = 1'b0;
    logic [4:0] tbase = '0;
    logic       rel = 1'b0;
    logic       hv, full, ovf;
    logic [4:0] hs;
    logic [3:0] hc;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tot_hit_recorder i_tot_hit_recorder (
        .clk(clk), .rst(rst), .disc_i(disc), .tbase_i(tbase), .release_i(rel),
        .head_valid_o(hv), .head_stamp_o(hs), .head_code_o(hc),
        .full_o(full), .overflow_o(ovf)
    );

    function automatic int exp_code(input int n);
        int p, m, c;
        p = 0; m = n;
        while (m > 1) begin m = m >> 1; p++; end
        if (p == 0) return 1;
        c = 2 * p + ((n >> (p - 1)) & 1);
        return (c > 15) ? 15 : c;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drives a pulse of n high samples; returns just after the storing edge
    task automatic hit(input int n, input int ts);
        @(negedge clk); disc = 1'b1; tbase = 5'(ts);
        for (int i = 1; i < n; i++) begin
            @(negedge clk); tbase = 5'(ts + i);
        end
        @(negedge clk); disc = 1'b0; tbase = 5'(ts + 99);
        @(posedge clk); #1;
    endtask

    task automatic pop();
        @(negedge clk); rel = 1'b1;
        @(negedge clk); rel = 1'b0;
        #1;
    endtask

    task automatic head_is(input string req, input int ts, input int n);
        chk(req, hv, 1);
        chk(req, hs, ts % 32);
        chk(req, hc, exp_code(n));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 valid", hv, 0); chk("R1 full", full, 0); chk("R1 ovf", ovf, 0);

        // R2 R3 R4: length sweep, time base moves through its wrap
        for (int n = 1; n <= 200; n++) begin
            hit(n, n * 7 + 20);
            head_is("R4 sweep", n * 7 + 20, n);
            pop();
            chk("R5 drained", hv, 0);
        end
        hit(300, 31);
        head_is("R4 saturation", 31, 300);
        pop();

        // R5 order and full flag
        hit(1, 3); hit(2, 9); hit(3, 17);
        chk("R5 not full at 3", full, 0);
        hit(5, 30);
        chk("R5 full at 4", full, 1);
        chk("R6 no ovf yet", ovf, 0);
        hit(7, 11);
        chk("R6 ovf set", ovf, 1);
        head_is("R6 head kept", 3, 1);
        pop(); head_is("R5 order 2", 9, 2);
        pop(); head_is("R5 order 3", 17, 3);
        pop(); head_is("R5 order 4", 30, 5);
        chk("R6 ovf sticky", ovf, 1);
        pop(); chk("R6 dropped absent", hv, 0);

        // R7: release while full on the same edge a hit completes
        hit(1, 1); hit(2, 2); hit(3, 3); hit(4, 4);
        @(negedge clk); disc = 1'b1; tbase = 5'd25;
        @(negedge clk); disc = 1'b0; rel = 1'b1;
        @(negedge clk); rel = 1'b0; #1;
        chk("R7 not full after release", full, 0);
        head_is("R7 head advanced", 2, 2);
        hit(4, 12);
        chk("R7 refill next cycle", full, 1);
        pop(); head_is("R7 order a", 3, 3);
        pop(); head_is("R7 order b", 4, 4);
        pop(); head_is("R7 refilled hit", 12, 4);
        pop(); chk("R7 empty", hv, 0);

        // R8: release on empty store
        pop(); pop();
        chk("R8 still empty", hv, 0);
        hit(6, 14);
        head_is("R8 next hit", 14, 6);
        chk("R8 not full", full, 0);

        // R9: concurrent store and release with one entry stored
        @(negedge clk); disc = 1'b1; tbase = 5'd8;
        @(negedge clk); tbase = 5'd9;
        @(negedge clk); disc = 1'b0; rel = 1'b1;
        @(negedge clk); rel = 1'b0; #1;
        head_is("R9 new head", 8, 2);
        pop(); chk("R9 one entry only", hv, 0);

        // R1: reset clears the sticky flag
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk("R1 ovf cleared", ovf, 0);
        chk("R1 valid cleared", hv, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule